// File: doc/BRIEF.md
# Interrupt Enable/Flag and Build Identification Register Block

This block sits on a 16-bit peripheral bus. It holds an enable bit and a pending-flag bit for two system interrupt sources: the non-maskable interrupt and the watchdog interval interrupt. Each source is fed to the block as a one-cycle event pulse from logic outside it. A flag is set by its event and can be set or cleared by software through a bus write. The block drives an interrupt request for each source while both that source's flag and its enable are set.

The block also holds two read-only identification words. They are built from parameters when the design is elaborated and describe the configuration: core revision, a custom-silicon flag, an integrator revision, the size of the peripheral space, the data-memory size, the program-memory size and whether a multiplier is present. Each source can be left out of a build with a parameter, and its bits then read as zero.

Reads are combinational in the same cycle. Writes take effect at the next clock edge. The reset input is asynchronous and active low; the block releases it synchronously through two flops.

Top module: `sfr_block`

## Requirements
- R1: After reset, the enable word and the flag word read 0x0000, and both interrupt requests are low.
- R2: Byte addresses 0x0000, 0x0002, 0x0004 and 0x0006 select the enable word, the flag word, the low identification word and the high identification word. Address bit 0 is ignored. Read data appears in the same cycle that the address is presented.
- R3: In the enable word and in the flag word, bit 4 belongs to the NMI and bit 0 belongs to the watchdog. Bits 15:5 and 3:1 always read 0 and are not changed by any write.
- R4: Write-enable bit 0 writes bits 7:0 of the addressed word at the next edge. A write with only write-enable bit 1 set leaves the enable word and the flag word unchanged.
- R5: If nmi_evt is high at a clock edge, flag bit 4 is set at that edge. If wdt_evt is high at a clock edge, flag bit 0 is set at that edge. Each event wins over a software write of 0 to its own bit in the same cycle.
- R6: Software can set and can clear each present flag bit by writing the flag word.
- R7: nmi_irq is high exactly when flag bit 4 and enable bit 4 are both 1. wdt_irq is high exactly when flag bit 0 and enable bit 0 are both 1.
- R8: The low identification word is {USER_REV[4:0], ASIC_FLAG, CORE_REV[2:0], PER_BYTES/512 in 7 bits}, with the peripheral units in bits 6:0. The high identification word is {MPY_EN, PMEM_BYTES/1024 in 6 bits, DMEM_BYTES/128 in 9 bits}. Writes to either identification word have no effect.
- R9: bus_rdata is 0x0000 whenever bus_en is low or the address is outside the four words.
- R10: When NMI_EN is 0, bit 4 of both words reads 0 and nmi_irq stays low. When WDT_EN is 0, bit 0 of both words reads 0 and wdt_irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 2 | Per-byte write enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| nmi_evt | input | 1 | NMI event pulse |
| wdt_evt | input | 1 | Watchdog interval event pulse |
| nmi_irq | output | 1 | Qualified NMI request |
| wdt_irq | output | 1 | Qualified watchdog request |

## Verification
Random bus traffic writes random data, with random byte enables, to addresses inside and outside the map, while both event inputs pulse at random. After each operation the bench compares both words and both requests against a model. This separates three faults: writes that land in the wrong byte or in reserved bits, events that are lost when they coincide with a clearing write, and requests that are gated by the wrong bit. Directed cases cover odd addresses, writes that use only the high byte enable, writes to the identification words and reads with the bus idle. A second instance built without the NMI shows that bit 4 stays zero while the watchdog bit keeps working.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int DATA_W = 16;
  localparam int REG_W  = 8;
  localparam int NMI_BIT = 4;
  localparam int WDT_BIT = 0;
  localparam int NWORDS = 4;
  localparam int IDX_W  = $clog2(NWORDS);

  typedef enum logic [IDX_W-1:0] {
    W_IE   = 2'd0,
    W_IFG  = 2'd1,
    W_IDLO = 2'd2,
    W_IDHI = 2'd3
  } word_e;
endpackage

// File: rtl/sfr_addr_dec.sv
module sfr_addr_dec
  import sfr_pkg::*;
#(
  parameter int             WA_W    = 13,
  parameter logic [WA_W-1:0] BASE_WA = '0
) (
  input  logic              en,
  input  logic [WA_W-1:0]   word_addr,
  output logic [NWORDS-1:0] sel
);
  logic hit;

  // Upper address bits must match the base; lower bits pick the word
  assign hit = en && (word_addr[WA_W-1:IDX_W] == BASE_WA[WA_W-1:IDX_W]);

  for (genvar g = 0; g < NWORDS; g++) begin : g_sel
    assign sel[g] = hit && (word_addr[IDX_W-1:0] == IDX_W'(g));
  end
endmodule

// File: rtl/sfr_bit_cell.sv
module sfr_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o
);
  logic q_nxt;
  logic q_en;

  // A hardware set wins over a software write in the same cycle
  always_comb begin
    q_en  = set_i | wr_i;
    q_nxt = set_i ? 1'b1 : d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_nxt;
  end
endmodule

// File: rtl/sfr_id_words.sv
module sfr_id_words
  import sfr_pkg::*;
#(
  parameter logic [2:0] CORE_REV   = 3'd2,
  parameter bit         ASIC_FLAG  = 1'b0,
  parameter logic [4:0] USER_REV   = 5'd7,
  parameter int         PER_BYTES  = 512,
  parameter bit         MPY_EN     = 1'b1,
  parameter int         DMEM_BYTES = 1024,
  parameter int         PMEM_BYTES = 4096
) (
  output logic [DATA_W-1:0] id_lo,
  output logic [DATA_W-1:0] id_hi
);
  localparam int PER_UNITS  = PER_BYTES / 512;
  localparam int DMEM_UNITS = DMEM_BYTES / 128;
  localparam int PMEM_UNITS = PMEM_BYTES / 1024;

  assign id_lo = {USER_REV, ASIC_FLAG, CORE_REV, 7'(PER_UNITS)};
  assign id_hi = {MPY_EN, 6'(PMEM_UNITS), 9'(DMEM_UNITS)};
endmodule

// File: rtl/sfr_block.sv
module sfr_block
  import sfr_pkg::*;
#(
  parameter int         ADDR_W     = 14,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter bit         NMI_EN     = 1'b1,
  parameter bit         WDT_EN     = 1'b1,
  parameter logic [2:0] CORE_REV   = 3'd2,
  parameter bit         ASIC_FLAG  = 1'b0,
  parameter logic [4:0] USER_REV   = 5'd7,
  parameter int         PER_BYTES  = 512,
  parameter bit         MPY_EN     = 1'b1,
  parameter int         DMEM_BYTES = 1024,
  parameter int         PMEM_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              nmi_evt,
  input  logic              wdt_evt,
  output logic              nmi_irq,
  output logic              wdt_irq
);
  localparam int WA_W = ADDR_W - 1;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // Word decode
  logic [NWORDS-1:0] word_sel;

  sfr_addr_dec #(
    .WA_W    (WA_W),
    .BASE_WA (BASE_ADDR[ADDR_W-1:1])
  ) u_dec (
    .en        (bus_en),
    .word_addr (bus_addr[ADDR_W-1:1]),
    .sel       (word_sel)
  );

  logic wr_ie;
  logic wr_ifg;
  assign wr_ie  = word_sel[W_IE]  & bus_we[0];
  assign wr_ifg = word_sel[W_IFG] & bus_we[0];

  // Enable and flag bits; only the two source positions hold storage
  logic [REG_W-1:0] ie_q;
  logic [REG_W-1:0] ifg_q;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    localparam bit IS_NMI  = (b == NMI_BIT);
    localparam bit IS_WDT  = (b == WDT_BIT);
    localparam bit PRESENT = (IS_NMI && NMI_EN) || (IS_WDT && WDT_EN);

    if (PRESENT) begin : g_live
      logic evt;
      assign evt = IS_NMI ? nmi_evt : wdt_evt;

      sfr_bit_cell u_ie (
        .clk   (clk),
        .rst_n (rst_n_s),
        .set_i (1'b0),
        .wr_i  (wr_ie),
        .d_i   (bus_wdata[b]),
        .q_o   (ie_q[b])
      );

      sfr_bit_cell u_ifg (
        .clk   (clk),
        .rst_n (rst_n_s),
        .set_i (evt),
        .wr_i  (wr_ifg),
        .d_i   (bus_wdata[b]),
        .q_o   (ifg_q[b])
      );
    end else begin : g_void
      assign ie_q[b]  = 1'b0;
      assign ifg_q[b] = 1'b0;
    end
  end

  // Identification words
  logic [DATA_W-1:0] id_lo;
  logic [DATA_W-1:0] id_hi;

  sfr_id_words #(
    .CORE_REV   (CORE_REV),
    .ASIC_FLAG  (ASIC_FLAG),
    .USER_REV   (USER_REV),
    .PER_BYTES  (PER_BYTES),
    .MPY_EN     (MPY_EN),
    .DMEM_BYTES (DMEM_BYTES),
    .PMEM_BYTES (PMEM_BYTES)
  ) u_id (
    .id_lo (id_lo),
    .id_hi (id_hi)
  );

  // Read mux: select lines are one-hot or all zero
  always_comb begin
    bus_rdata = '0;
    if (word_sel[W_IE])   bus_rdata = bus_rdata | {{(DATA_W-REG_W){1'b0}}, ie_q};
    if (word_sel[W_IFG])  bus_rdata = bus_rdata | {{(DATA_W-REG_W){1'b0}}, ifg_q};
    if (word_sel[W_IDLO]) bus_rdata = bus_rdata | id_lo;
    if (word_sel[W_IDHI]) bus_rdata = bus_rdata | id_hi;
  end

  assign nmi_irq = ifg_q[NMI_BIT] & ie_q[NMI_BIT];
  assign wdt_irq = ifg_q[WDT_BIT] & ie_q[WDT_BIT];

  logic unused_sink;
  assign unused_sink = ^{bus_addr[0], bus_wdata[15:8], bus_wdata[7:5],
                         bus_wdata[3:1], bus_we[1]};
endmodule

// File: rtl/sfr_block_chk.sv
module sfr_block_chk #(
  parameter bit NMI_EN = 1'b1,
  parameter bit WDT_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic [1:0]  bus_we,
  input logic [15:0] bus_rdata,
  input logic        nmi_evt,
  input logic        wdt_evt,
  input logic        nmi_irq,
  input logic        wdt_irq,
  input logic [7:0]  ie_q,
  input logic [7:0]  ifg_q,
  input logic [3:0]  sel
);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_rdata == 16'h0000);

  // R5
  wdt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && WDT_EN) |=> ifg_q[0]);

  // R5
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt && NMI_EN) |=> ifg_q[4]);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ie_q | ifg_q) & 8'hEE) == 8'h00);

  // R7
  wdt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> (ie_q[0] && ifg_q[0]));

  // R7
  nmi_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_irq |-> (ie_q[4] && ifg_q[4]));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R4
  hi_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[0] && bus_we == 2'b10) |=> $stable(ie_q));
endmodule

bind sfr_block sfr_block_chk #(
  .NMI_EN (NMI_EN),
  .WDT_EN (WDT_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .nmi_evt   (nmi_evt),
  .wdt_evt   (wdt_evt),
  .nmi_irq   (nmi_irq),
  .wdt_irq   (wdt_irq),
  .ie_q      (ie_q),
  .ifg_q     (ifg_q),
  .sel       (word_sel)
);

// File: tb/sim_sfr_block.sv
`timescale 1ns/1ps
module sim_sfr_block;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en;
  logic [13:0] bus_addr;
  logic [1:0]  bus_we;
  logic [15:0] bus_wdata;
  logic        nmi_evt, wdt_evt;
  logic [15:0] rdata0, rdata1;
  logic        nmi_irq0, wdt_irq0, nmi_irq1, wdt_irq1;

  always #2 clk = ~clk;

  sfr_block u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .nmi_evt(nmi_evt), .wdt_evt(wdt_evt), .nmi_irq(nmi_irq0), .wdt_irq(wdt_irq0)
  );

  sfr_block #(.NMI_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .nmi_evt(nmi_evt), .wdt_evt(wdt_evt), .nmi_irq(nmi_irq1), .wdt_irq(wdt_irq1)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] ie0, ifg0, ie1, ifg1;
  logic [15:0] rd0, rd1;

  localparam logic [15:0] EXP_IDLO = {5'd7, 1'b0, 3'd2, 7'(512/512)};
  localparam logic [15:0] EXP_IDHI = {1'b1, 6'(4096/1024), 9'(1024/128)};

  function automatic logic [7:0] nxt(input logic [7:0] cur, input logic wr,
                                     input logic [7:0] d, input logic [7:0] setm,
                                     input logic [7:0] mask);
    logic [7:0] r;
    r = wr ? d : cur;
    r = r | setm;
    return r & mask;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic en, input logic [13:0] a, input logic [15:0] d,
                    input logic [1:0] we, input logic n, input logic w);
    logic wr_ie, wr_ifg;
    @(negedge clk);
    bus_en = en; bus_addr = a; bus_wdata = d; bus_we = we;
    nmi_evt = n; wdt_evt = w;
    @(negedge clk);
    wr_ie  = en && (a[13:1] == 13'd0) && we[0];
    wr_ifg = en && (a[13:1] == 13'd1) && we[0];
    ie0  = nxt(ie0,  wr_ie,  d[7:0], 8'h00, 8'h11);
    ifg0 = nxt(ifg0, wr_ifg, d[7:0], {3'b0, n, 3'b0, w}, 8'h11);
    ie1  = nxt(ie1,  wr_ie,  d[7:0], 8'h00, 8'h01);
    ifg1 = nxt(ifg1, wr_ifg, d[7:0], {3'b0, n, 3'b0, w}, 8'h01);
    bus_en = 1'b0; bus_we = 2'b00; nmi_evt = 1'b0; wdt_evt = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a);
    @(negedge clk);
    bus_en = 1'b1; bus_addr = a; bus_we = 2'b00;
    #1;
    rd0 = rdata0; rd1 = rdata1;
    bus_en = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    rd(14'h0000);
    chk({tag, " R3 u0 enable"}, rd0, {8'h00, ie0});
    chk({tag, " R10 u1 enable"}, rd1, {8'h00, ie1});
    rd(14'h0002);
    chk({tag, " R3 u0 flag"}, rd0, {8'h00, ifg0});
    chk({tag, " R10 u1 flag"}, rd1, {8'h00, ifg1});
    chk({tag, " R7 u0 irqs"}, {14'h0, nmi_irq0, wdt_irq0},
        {14'h0, ie0[4] & ifg0[4], ie0[0] & ifg0[0]});
    chk({tag, " R10 u1 irqs"}, {14'h0, nmi_irq1, wdt_irq1},
        {14'h0, 1'b0, ie1[0] & ifg1[0]});
  endtask

  // Watchdog: an expired run counts as a failure
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0; bus_en = 1'b0; bus_addr = '0; bus_we = '0; bus_wdata = '0;
    nmi_evt = 1'b0; wdt_evt = 1'b0;
    ie0 = 8'h00; ifg0 = 8'h00; ie1 = 8'h00; ifg1 = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_regs("R1 reset");

    // R8 identification words, unaffected by writes
    rd(14'h0004); chk("R8 id low", rd0, EXP_IDLO);
    rd(14'h0006); chk("R8 id high", rd0, EXP_IDHI);
    op(1'b1, 14'h0004, 16'hFFFF, 2'b11, 1'b0, 1'b0);
    op(1'b1, 14'h0006, 16'h0000, 2'b11, 1'b0, 1'b0);
    rd(14'h0004); chk("R8 id low after write", rd0, EXP_IDLO);
    rd(14'h0006); chk("R8 id high after write", rd0, EXP_IDHI);

    // R3 reserved bits ignore writes
    op(1'b1, 14'h0000, 16'hFFFF, 2'b11, 1'b0, 1'b0);
    check_regs("R3 all ones");

    // R4 high byte enable alone changes nothing
    op(1'b1, 14'h0000, 16'h0000, 2'b10, 1'b0, 1'b0);
    check_regs("R4 high only");

    // R6 software set then clear
    op(1'b1, 14'h0002, 16'h0011, 2'b01, 1'b0, 1'b0);
    check_regs("R6 set");
    op(1'b1, 14'h0002, 16'h0000, 2'b01, 1'b0, 1'b0);
    check_regs("R6 clear");

    // R5 event wins over a same-cycle clearing write
    op(1'b1, 14'h0002, 16'h0000, 2'b01, 1'b1, 1'b1);
    chk("R5 model flag", {8'h0, ifg0}, 16'h0011);
    check_regs("R5 priority");

    // R2 odd address maps to the flag word
    rd(14'h0003); chk("R2 odd address", rd0, {8'h00, ifg0});

    // R9 idle bus and unmapped addresses
    @(negedge clk); bus_en = 1'b0; bus_addr = 14'h0000; #1;
    chk("R9 idle bus", rdata0, 16'h0000);
    rd(14'h0008); chk("R9 outside map", rd0, 16'h0000);
    rd(14'h0100); chk("R9 far address", rd0, 16'h0000);

    // Random traffic
    for (int i = 0; i < 300; i++) begin
      logic [13:0] a;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0, 3'd1: a = 14'h0000;
        3'd2, 3'd3: a = 14'h0002;
        3'd4:       a = 14'h0001;
        3'd5:       a = 14'h0003;
        3'd6:       a = 14'h0004;
        default:    a = 14'($urandom);
      endcase
      op(1'($urandom_range(0, 3) != 0), a, 16'($urandom), 2'($urandom),
         1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
      check_regs("R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule